// File: doc/BRIEF.md
# Ring-Mapped Translation Buffer with Hardware Table Refill

This block translates 32-bit virtual addresses into physical addresses for one access at a time. It holds four ways of eight entries, each entry covering a fixed 4 KB page. An entry does not store a privilege ring. It stores an address-space tag, and the ring is recovered by searching the four tag bytes of a ring-tag register. A lookup either returns the physical address or a fault with a cause code. The cause codes differ for instruction fetches and for data accesses.

When no entry matches, the block fetches a page-table entry itself. It reads a word over a valid/ready memory port at an address built from a table-base input and the virtual page number. It then installs the entry in a way chosen round-robin and finishes the original request with the fetched entry. The request and response streams are valid/ready, with one request in flight. `req_ready` is high only while the block is idle. A response stays on its pins, unchanged, until `rsp_ready` is seen. The table-read request holds its address until `pt_req_ready`. `pt_rsp_ready` is high only while the block waits for the table word. The ring-tag write pins, the table base and the exception address are plain control and status pins.

Top module: `tlb_autorefill`

## Requirements
- R1: After reset the ring-tag register reads 0x04030201, every entry tag is 0, the refill counter is 0, `exc_vaddr` is 0, `req_ready` is 1, and `rsp_valid` and `pt_req_valid` are 0. As a result the first lookup of any address misses.
- R2: The set index is vaddr[14:12]. An entry hits when its stored page number equals vaddr[31:12], its tag is nonzero, and its tag equals one of the four bytes of the ring-tag register. Its ring is the lowest byte index (0 to 3) that holds that tag.
- R3: When exactly one way hits and no privilege fault applies, the response has `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {entry page, vaddr[11:0]}.
- R4: When two or more ways hit, the response is a fault with cause 3 for an execute access or 4 for a read or write, and `rsp_paddr`=0.
- R5: If the ring used for a translation is numerically below `req_priv`, the response is a fault with cause 5 for execute or 6 for data, and `rsp_paddr`=0.
- R6: On a miss the block sets `exc_vaddr` to the request address. It then reads the table word at (`pt_base` OR (vaddr >> 10)) with bits [1:0] cleared.
- R7: A successful table read increments the refill counter (mod 4). It installs, in the way equal to the new counter value and at the request's set: page = vaddr[31:12], physical page = word[31:12], tag = byte word[5:4] of the ring-tag register. The response then applies R3/R5 with ring = word[5:4].
- R8: A table read returned with `pt_rsp_err`=1 gives a fault with cause 1 for execute or 2 for data. In that case nothing is installed and the counter is unchanged.
- R9: There is one request in flight. `req_ready` is high only when idle. The response holds stable until `rsp_ready`. `pt_req_valid` holds with a stable address until `pt_req_ready`.
- R10: `rasid_we`=1 loads `rasid_wdata` into the ring-tag register on the clock edge. The new value shows on `ring_asid` and applies to lookups accepted afterwards.
- R11: `req_kind` encodes 0 = read, 1 = write, 2 = execute. Only execute selects the instruction-side cause codes 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_priv | input | 2 | Requesting privilege ring |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 4 | Fault cause code, 0 when no fault |
| pt_req_valid | output | 1 | Table read request valid |
| pt_req_ready | input | 1 | Table read request accepted |
| pt_req_addr | output | 32 | Table word address |
| pt_rsp_valid | input | 1 | Table word valid |
| pt_rsp_ready | output | 1 | Block waiting for table word |
| pt_rsp_data | input | 32 | Table word |
| pt_rsp_err | input | 1 | Table read failed |
| rasid_we | input | 1 | Ring-tag register write strobe |
| rasid_wdata | input | 32 | Ring-tag write value |
| ring_asid | output | 32 | Current ring-tag register |
| pt_base | input | 32 | Table base address |
| exc_vaddr | output | 32 | Address of the most recent miss |

## Verification
Directed sequences run first. They cover a cold miss followed by a hit on the same page, a privilege fault on a freshly installed page, a failed table read followed by a good one, and five pages competing for one set so that round-robin eviction shows up as a repeat miss. The multi-hit case is built by rewriting the ring-tag register so that an old entry hides, a second copy is installed, and then both are exposed together. Ring-tag values with a zero byte and with duplicated bytes separate tag-zero entries from lowest-ring selection. Random traffic then draws from six page tags over all eight sets, with mixed access kinds, privileges and injected table errors. This separates eviction order, cause-code side and ring decoding from one another.

// File: rtl/tlb_ar_pkg.sv
package tlb_ar_pkg;
  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2} acc_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_PTREQ, ST_PTWAIT, ST_RESP} tlb_state_e;

  localparam int NRINGS  = 4;
  localparam int RING_W  = 2;
  localparam int CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_IMISS  = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_DMISS  = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_IMULTI = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_DMULTI = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_IPRIV  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_DPRIV  = 4'd6;
endpackage

// File: rtl/tlb_ar_store.sv
module tlb_ar_store #(
  parameter int NWAYS  = 4,
  parameter int NSETS  = 8,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IDX_W  = $clog2(NSETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [NWAYS-1:0]  wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  output logic [VPN_W-1:0]  rd_vpn  [NWAYS],
  output logic [PPN_W-1:0]  rd_ppn  [NWAYS],
  output logic [ASID_W-1:0] rd_asid [NWAYS]
);
  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [VPN_W-1:0]  vpn_q  [NSETS];
    logic [PPN_W-1:0]  ppn_q  [NSETS];
    logic [ASID_W-1:0] asid_q [NSETS];

    // only the tag needs a reset: a zero tag masks the other fields
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < NSETS; s++) asid_q[s] <= '0;
      end else if (wr_en[w]) begin
        asid_q[wr_idx] <= wr_asid;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[w]) begin
        vpn_q[wr_idx] <= wr_vpn;
        ppn_q[wr_idx] <= wr_ppn;
      end
    end

    assign rd_vpn[w]  = vpn_q[rd_idx];
    assign rd_ppn[w]  = ppn_q[rd_idx];
    assign rd_asid[w] = asid_q[rd_idx];
  end

  // R7
  way_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/tlb_ar_match.sv
module tlb_ar_match
  import tlb_ar_pkg::*;
#(
  parameter int NWAYS  = 4,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int WAY_W  = $clog2(NWAYS)
) (
  input  logic [VPN_W-1:0]         look_vpn,
  input  logic [VPN_W-1:0]         rd_vpn  [NWAYS],
  input  logic [ASID_W-1:0]        rd_asid [NWAYS],
  input  logic [NRINGS*ASID_W-1:0] ring_asid,
  output logic [NWAYS-1:0]         hit_vec,
  output logic [WAY_W-1:0]         hit_way,
  output logic [RING_W-1:0]        hit_ring
);
  logic [RING_W-1:0] way_ring [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    always_comb begin
      logic found;
      found       = 1'b0;
      way_ring[w] = '0;
      for (int r = NRINGS - 1; r >= 0; r--) begin
        if (rd_asid[w] != '0 && ring_asid[r*ASID_W +: ASID_W] == rd_asid[w]) begin
          found       = 1'b1;
          way_ring[w] = RING_W'(r);
        end
      end
      hit_vec[w] = found && (rd_vpn[w] == look_vpn);
    end
  end

  // lowest hitting way wins; only meaningful for a single hit
  always_comb begin
    hit_way  = '0;
    hit_ring = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_ring = way_ring[w];
      end
    end
  end
endmodule

// File: rtl/tlb_autorefill.sv
module tlb_autorefill
  import tlb_ar_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int NWAYS     = 4,
  parameter int NSETS     = 8,
  parameter int ASID_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [1:0]               req_kind,
  input  logic [RING_W-1:0]        req_priv,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [VA_W-1:0]          rsp_paddr,
  output logic                     rsp_fault,
  output logic [CAUSE_W-1:0]       rsp_cause,
  output logic                     pt_req_valid,
  input  logic                     pt_req_ready,
  output logic [VA_W-1:0]          pt_req_addr,
  input  logic                     pt_rsp_valid,
  output logic                     pt_rsp_ready,
  input  logic [VA_W-1:0]          pt_rsp_data,
  input  logic                     pt_rsp_err,
  input  logic                     rasid_we,
  input  logic [NRINGS*ASID_W-1:0] rasid_wdata,
  output logic [NRINGS*ASID_W-1:0] ring_asid,
  input  logic [VA_W-1:0]          pt_base,
  output logic [VA_W-1:0]          exc_vaddr
);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int IDX_W     = $clog2(NSETS);
  localparam int WAY_W     = $clog2(NWAYS);
  localparam int PTE_SHIFT = PAGE_BITS - 2;
  localparam int PTE_RING  = 4;

  function automatic logic [NRINGS*ASID_W-1:0] rasid_init();
    logic [NRINGS*ASID_W-1:0] v;
    for (int i = 0; i < NRINGS; i++) v[i*ASID_W +: ASID_W] = ASID_W'(i + 1);
    return v;
  endfunction

  tlb_state_e               state_q;
  logic [VA_W-1:0]          va_q, paddr_q, exc_q, pta_q;
  logic [1:0]               kind_q;
  logic [RING_W-1:0]        priv_q;
  logic                     fault_q;
  logic [CAUSE_W-1:0]       cause_q;
  logic [NRINGS*ASID_W-1:0] rasid_q;
  logic [WAY_W-1:0]         ar_q;

  logic [VPN_W-1:0]  look_vpn;
  logic [IDX_W-1:0]  look_idx;
  logic [VPN_W-1:0]  rd_vpn  [NWAYS];
  logic [VPN_W-1:0]  rd_ppn  [NWAYS];
  logic [ASID_W-1:0] rd_asid [NWAYS];
  logic [NWAYS-1:0]  hit_vec, wr_en;
  logic [WAY_W-1:0]  hit_way, fill_way;
  logic [RING_W-1:0] hit_ring, pte_ring, fin_ring;
  logic [VPN_W-1:0]  fin_ppn;
  logic              any_hit, multi_hit, fill_go, is_inst, priv_bad;
  logic [ASID_W-1:0] fill_asid;
  logic              pte_unused;

  assign look_vpn  = va_q[VA_W-1:PAGE_BITS];
  assign look_idx  = va_q[PAGE_BITS +: IDX_W];
  assign is_inst   = (kind_q == ACC_EX);
  assign pte_ring  = pt_rsp_data[PTE_RING +: RING_W];
  assign fill_way  = ar_q + 1'b1;
  assign fill_asid = rasid_q[pte_ring*ASID_W +: ASID_W];
  assign fill_go   = (state_q == ST_PTWAIT) && pt_rsp_valid && !pt_rsp_err;
  assign any_hit   = |hit_vec;
  assign multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
  assign pte_unused = ^{pt_rsp_data[PAGE_BITS-1:PTE_RING+RING_W], pt_rsp_data[PTE_RING-1:0]};

  for (genvar w = 0; w < NWAYS; w++) begin : g_we
    assign wr_en[w] = fill_go && (fill_way == WAY_W'(w));
  end

  tlb_ar_store #(.NWAYS(NWAYS), .NSETS(NSETS), .VPN_W(VPN_W), .PPN_W(VPN_W),
                 .ASID_W(ASID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(look_idx), .wr_en(wr_en), .wr_idx(look_idx),
    .wr_vpn(look_vpn), .wr_ppn(pt_rsp_data[VA_W-1:PAGE_BITS]), .wr_asid(fill_asid),
    .rd_vpn(rd_vpn), .rd_ppn(rd_ppn), .rd_asid(rd_asid));

  tlb_ar_match #(.NWAYS(NWAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .look_vpn(look_vpn), .rd_vpn(rd_vpn), .rd_asid(rd_asid), .ring_asid(rasid_q),
    .hit_vec(hit_vec), .hit_way(hit_way), .hit_ring(hit_ring));

  // a hit and a refill share the ring/privilege check
  always_comb begin
    if (state_q == ST_LOOK) begin
      fin_ring = hit_ring;
      fin_ppn  = rd_ppn[hit_way];
    end else begin
      fin_ring = pte_ring;
      fin_ppn  = pt_rsp_data[VA_W-1:PAGE_BITS];
    end
    priv_bad = fin_ring < priv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rasid_q <= rasid_init();
    else if (rasid_we) rasid_q <= rasid_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      kind_q  <= '0;
      priv_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      exc_q   <= '0;
      pta_q   <= '0;
      ar_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          kind_q  <= req_kind;
          priv_q  <= req_priv;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (multi_hit) begin
            fault_q <= 1'b1;
            cause_q <= is_inst ? CAUSE_IMULTI : CAUSE_DMULTI;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else if (any_hit) begin
            fault_q <= priv_bad;
            cause_q <= priv_bad ? (is_inst ? CAUSE_IPRIV : CAUSE_DPRIV) : CAUSE_NONE;
            paddr_q <= priv_bad ? '0 : {fin_ppn, va_q[PAGE_BITS-1:0]};
            state_q <= ST_RESP;
          end else begin
            exc_q   <= va_q;
            pta_q   <= (pt_base | (va_q >> PTE_SHIFT)) & ~VA_W'(3);
            state_q <= ST_PTREQ;
          end
        end
        ST_PTREQ: if (pt_req_ready) state_q <= ST_PTWAIT;
        ST_PTWAIT: if (pt_rsp_valid) begin
          if (pt_rsp_err) begin
            fault_q <= 1'b1;
            cause_q <= is_inst ? CAUSE_IMISS : CAUSE_DMISS;
            paddr_q <= '0;
          end else begin
            ar_q    <= fill_way;
            fault_q <= priv_bad;
            cause_q <= priv_bad ? (is_inst ? CAUSE_IPRIV : CAUSE_DPRIV) : CAUSE_NONE;
            paddr_q <= priv_bad ? '0 : {fin_ppn, va_q[PAGE_BITS-1:0]};
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign pt_req_valid = (state_q == ST_PTREQ);
  assign pt_rsp_ready = (state_q == ST_PTWAIT);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign rsp_cause    = cause_q;
  assign pt_req_addr  = pta_q;
  assign ring_asid    = rasid_q;
  assign exc_vaddr    = exc_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause) && $stable(rsp_fault)));
  // R9
  ptreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_addr)));
  // R4
  multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK && $countones(hit_vec) > 1) |=>
      (rsp_valid && rsp_fault && (rsp_cause == CAUSE_IMULTI || rsp_cause == CAUSE_DMULTI)));
  // R8
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_rsp_ready && pt_rsp_valid && pt_rsp_err) |=>
      (rsp_valid && rsp_fault && (rsp_cause == CAUSE_IMISS || rsp_cause == CAUSE_DMISS)));
endmodule

// File: tb/tlb_autorefill_bench.sv
module tlb_autorefill_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0, rasid_we = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault, pt_req_valid, pt_rsp_ready;
  logic [31:0] req_vaddr = '0, rasid_wdata = '0, pt_base = 32'h4000_0000;
  logic [1:0]  req_kind = '0, req_priv = '0;
  logic [31:0] rsp_paddr, pt_req_addr, ring_asid, exc_vaddr;
  logic [3:0]  rsp_cause;
  logic        pt_req_ready, pt_rsp_valid, pt_rsp_err;
  logic [31:0] pt_rsp_data;

  always #2 clk = ~clk;

  tlb_autorefill u_tlb_autorefill (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .pt_req_valid(pt_req_valid),
    .pt_req_ready(pt_req_ready), .pt_req_addr(pt_req_addr), .pt_rsp_valid(pt_rsp_valid),
    .pt_rsp_ready(pt_rsp_ready), .pt_rsp_data(pt_rsp_data), .pt_rsp_err(pt_rsp_err),
    .rasid_we(rasid_we), .rasid_wdata(rasid_wdata), .ring_asid(ring_asid),
    .pt_base(pt_base), .exc_vaddr(exc_vaddr));

  int n_chk = 0, n_bad = 0;
  logic [19:0] m_vpn  [4][8];
  logic [19:0] m_ppn  [4][8];
  logic [7:0]  m_asid [4][8];
  logic [1:0]  m_ar;
  logic [31:0] m_rasid;
  bit          pt_err_next = 1'b0;
  logic [31:0] last_pta = '0;
  int          pt_reads = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_fn(input logic [31:0] a);
    logic [1:0] r;
    r = a[3:2] ^ a[5:4] ^ a[7:6];
    return {a[21:2] ^ 20'h5A3C1, 6'd0, r, 4'd0};
  endfunction

  function automatic int ring_of(input logic [7:0] tag, input logic [31:0] rv);
    if (tag == 8'd0) return -1;
    for (int i = 0; i < 4; i++) if (rv[i*8 +: 8] == tag) return i;
    return -1;
  endfunction

  task automatic set_rasid(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1'b1; rasid_wdata = v;
    @(negedge clk);
    rasid_we = 1'b0;
    m_rasid = v;
    chk(ring_asid == v, "R10 ring-tag write", ring_asid, v);
  endtask

  task automatic txn(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv, input bit err);
    int idx, nh, hr, r, t, d, reads0;
    logic [19:0] vpn, hp;
    logic [31:0] e_pa, pta, pte;
    logic [3:0] e_c;
    bit e_f, e_miss, is_i;
    string tag;
    idx = int'(va[14:12]); vpn = va[31:12]; nh = 0; hr = 0; hp = '0;
    is_i = (kind == 2'd2); e_miss = 1'b0;
    pta = (pt_base | (va >> 10)) & 32'hFFFF_FFFC;
    for (int w = 0; w < 4; w++) begin
      r = ring_of(m_asid[w][idx], m_rasid);
      if (r >= 0 && m_vpn[w][idx] == vpn) begin
        nh++;
        if (nh == 1) begin hr = r; hp = m_ppn[w][idx]; end
      end
    end
    if (nh > 1) begin
      e_f = 1; e_c = is_i ? 4'd3 : 4'd4; e_pa = 0; tag = "R4 multi-hit";
    end else begin
      if (nh == 0) begin
        e_miss = 1'b1;
        if (err) begin
          e_f = 1; e_c = is_i ? 4'd1 : 4'd2; e_pa = 0; tag = "R8 table error";
        end else begin
          pte = pte_fn(pta);
          m_ar = m_ar + 2'd1;
          m_vpn[m_ar][idx] = vpn; m_ppn[m_ar][idx] = pte[31:12];
          m_asid[m_ar][idx] = m_rasid[pte[5:4]*8 +: 8];
          hr = int'(pte[5:4]); hp = pte[31:12]; tag = "R7 refill";
        end
      end else tag = "R2/R3 hit";
      if (!(nh == 0 && err)) begin
        if (hr < int'(priv)) begin
          e_f = 1; e_c = is_i ? 4'd5 : 4'd6; e_pa = 0; tag = {tag, " R5 privilege"};
        end else begin
          e_f = 0; e_c = 0; e_pa = {hp, va[11:0]};
        end
      end
    end
    if (is_i) tag = {tag, " R11"};
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = priv;
    pt_err_next = err; reads0 = pt_reads;
    t = 0;
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
    chk(rsp_valid, {tag, " R9 response arrives"}, 32'(rsp_valid), 1);
    chk(rsp_fault == e_f, {tag, " fault"}, 32'(rsp_fault), 32'(e_f));
    chk(rsp_cause == e_c, {tag, " cause"}, 32'(rsp_cause), 32'(e_c));
    chk(rsp_paddr == e_pa, {tag, " paddr"}, rsp_paddr, e_pa);
    chk((pt_reads != reads0) == e_miss, "R7 table read only on miss", 32'(pt_reads - reads0), 32'(e_miss));
    if (e_miss) begin
      chk(last_pta == pta, "R6 table address", last_pta, pta);
      chk(exc_vaddr == va, "R6 exception address", exc_vaddr, va);
    end
    d = $urandom_range(0, 2);
    repeat (d) @(negedge clk);
    if (d > 0) chk(rsp_valid && rsp_paddr == e_pa && rsp_cause == e_c, "R9 response held", rsp_paddr, e_pa);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // table memory responder
  initial begin
    pt_req_ready = 1'b0; pt_rsp_valid = 1'b0; pt_rsp_data = '0; pt_rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      if (pt_req_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        pt_req_ready = 1'b1; last_pta = pt_req_addr; pt_reads++;
        @(negedge clk);
        pt_req_ready = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        pt_rsp_valid = 1'b1; pt_rsp_data = pte_fn(last_pta); pt_rsp_err = pt_err_next;
        while (!pt_rsp_ready) @(negedge clk);
        @(negedge clk);
        pt_rsp_valid = 1'b0; pt_rsp_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [16:0] hi_pool [6];
    logic [31:0] rv_pool [5];
    void'($urandom(32'd20240611));
    hi_pool = '{17'h0, 17'h1, 17'h2, 17'h155, 17'h1FFFF, 17'h0AAA};
    rv_pool = '{32'h04030201, 32'h01020304, 32'h04030200, 32'h11030201, 32'h04040201};
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 8; s++) begin m_asid[w][s] = 0; m_vpn[w][s] = 0; m_ppn[w][s] = 0; end
    m_ar = 0; m_rasid = 32'h04030201;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ring_asid == 32'h04030201, "R1 ring-tag reset", ring_asid, 32'h04030201);
    chk(req_ready == 1'b1, "R1 idle ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0 && pt_req_valid == 1'b0, "R1 no valids", 32'({rsp_valid, pt_req_valid}), 0);
    chk(exc_vaddr == 0, "R1 exception address reset", exc_vaddr, 0);
    // R1 cold miss, then hit
    txn(32'h0001_2345, 2'd0, 2'd0, 1'b0);
    txn(32'h0001_2ABC, 2'd1, 2'd0, 1'b0);
    // R5 ring 0 page used from privilege 1
    txn(32'h0000_0777, 2'd0, 2'd0, 1'b0);
    txn(32'h0000_0777, 2'd2, 2'd1, 1'b0);
    // R8 failed table read, then good one
    txn(32'h0055_5123, 2'd1, 2'd0, 1'b1);
    txn(32'h0055_5123, 2'd2, 2'd0, 1'b1);
    txn(32'h0055_5123, 2'd1, 2'd0, 1'b0);
    // R7 round-robin eviction: five pages in one set
    for (int k = 0; k < 5; k++) txn({17'(k + 100), 3'd5, 12'h010}, 2'd0, 2'd0, 1'b0);
    txn({17'd100, 3'd5, 12'h020}, 2'd0, 2'd0, 1'b0);
    // R10 zero byte: ring 0 entries installed with tag 0 never hit
    set_rasid(32'h04030200);
    txn(32'h0000_0100, 2'd0, 2'd0, 1'b0);
    txn(32'h0000_0100, 2'd0, 2'd0, 1'b0);
    // R4 build a duplicate: hide old entry, refill, expose both
    set_rasid(32'h04030201);
    txn(32'h0000_0200, 2'd0, 2'd0, 1'b0);
    set_rasid(32'h14131211);
    txn(32'h0000_0200, 2'd0, 2'd0, 1'b0);
    set_rasid(32'h04031101);
    txn(32'h0000_0200, 2'd2, 2'd0, 1'b0);
    txn(32'h0000_0200, 2'd1, 2'd0, 1'b0);
    set_rasid(32'h04030201);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va;
      logic [1:0] pr;
      if ($urandom_range(0, 24) == 0) set_rasid(rv_pool[$urandom_range(0, 4)]);
      va = {hi_pool[$urandom_range(0, 5)], 3'($urandom_range(0, 7)), 12'($urandom_range(0, 4095))};
      pr = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      txn(va, 2'($urandom_range(0, 2)), pr, $urandom_range(0, 7) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule